// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the pins of an asynchronous parallel flash bus. It turns the host's write cycles into operation requests for an internal program/erase engine. The chip-enable, write-enable and output-enable strobes are brought into the system clock domain, and a write is qualified there. The address of each write is caught when the write opens and the data when it closes. A state machine then matches the unlock-prefixed command sequences: byte program, chip erase, multi-sector erase, identifier read and protect unlock. It also handles the single-write reset and the erase suspend and resume commands.

The decoder emits single-cycle start pulses together with the latched operation address, data and a sector mask. The engine answers with done and fail pulses. Each mode accepts only its own commands. A malformed sequence falls back to array-read mode. A timed window lets several sectors be added to one erase before that erase is launched.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode reads 0 (read), the sector mask is 0 and no start, suspend, resume or unlock pulse is issued. Mode codes: 0 read, 1 identifier, 2 programming, 3 sector-load window, 4 erasing, 5 suspended, 6 suspended-programming, 7 fault.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by one write of data D at address A, give exactly one progStart pulse with opAddr=A and opData=D, and mode becomes 2. Only address bits 10..0 take part in the unlock and command compares.
- R3: A write is counted only while ceN and weN are both low and oeN is high. A WE pulse with oeN low has no effect.
- R4: A wrong address or data value in any cycle of a sequence returns mode to 0 without any start pulse.
- R5: In mode 2 every write is ignored. engDone returns the mode to 0.
- R6: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h gives eraseStart with chipErase=1 and all seven mask bits set, and mode becomes 4.
- R7: The same prefix ending in 30h at address S opens mode 3 and sets the mask bit of the sector holding S. Each later 30h write in the window adds a sector and restarts the window. The sector index is: 0 for 00000h-0FFFFh, 1 for 10000h-17FFFh, 2 for 18000h-19FFFh, 3 for 1A000h-1BFFFh, 4 for 1C000h-1CFFFh, 5 for 1D000h-1DFFFh and 6 for 1E000h-1FFFFh.
- R8: When WIN_CYCLES clocks pass in mode 3 with no sector load, eraseStart fires (chipErase=0) and mode becomes 4. Any write other than 30h or B0h in mode 3 returns mode to 0 with no erase started.
- R9: B0h in mode 4 gives a suspendReq pulse and mode 5. B0h in mode 3 closes the window at once: eraseStart and suspendReq fire together and mode becomes 5.
- R10: In mode 5 an unlocked program sequence starts a program (mode 6), and engDone in mode 6 returns to mode 5. 30h in mode 5 gives resumeReq and mode 4. In any other mode, 30h gives no resumeReq.
- R11: In mode 1, idValid is high and idData is C2h when addr[1:0]=00, the device code 19h when addr[1:0]=01, and {7'b0, chipProtected} when addr[1]=1. F0h returns to mode 0.
- R12: engFail during a program or an erase sets mode 7. Only F0h leaves mode 7, and it returns to mode 0.
- R13: F0h at any address, written part-way through an unlock prefix, returns mode to 0.
- R14: The erase prefix ending in 20h@555h gives one protUnlock pulse and mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Bus chip enable, active low, asynchronous |
| weN | input | 1 | Bus write enable, active low, asynchronous |
| oeN | input | 1 | Bus output enable, active low, asynchronous |
| addr | input | 17 | Bus address |
| dataIn | input | 8 | Bus write data |
| chipProtected | input | 1 | Current protection state, reported in identifier mode |
| engDone | input | 1 | Engine finished the current operation (pulse) |
| engFail | input | 1 | Engine exceeded its limit (pulse) |
| progStart | output | 1 | Byte program request pulse |
| eraseStart | output | 1 | Erase request pulse |
| chipErase | output | 1 | Qualifies eraseStart as a whole-chip erase |
| suspendReq | output | 1 | Erase suspend pulse |
| resumeReq | output | 1 | Erase resume pulse |
| protUnlock | output | 1 | Protect/unprotect unlock pulse |
| opAddr | output | 17 | Latched program address |
| opData | output | 8 | Latched program data |
| sectorMask | output | 7 | Sectors selected for erase |
| mode | output | 3 | Current mode code |
| idValid | output | 1 | High while identifier data is presented |
| idData | output | 8 | Identifier or protection code for the current address |

## Verification
A write takes effect four clock edges after weN rises: two edges in the synchronizer, one for the registered write event and one in the state machine, which also sets the pulse outputs. The bench holds weN high for six cycles before a write task returns. It therefore checks the mode only after that latency has passed, and it records the pulse outputs in a falling-edge monitor so that no one-cycle pulse is missed. Window expiry falls WIN_CYCLES+1 edges after the last sector load. The bench checks for mode 3 ten cycles before that point and for mode 4 ten cycles after it. The identifier output is combinational in the address, and it is sampled one cycle after the address changes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int NSECT = 7;

  typedef enum logic [2:0] {
    M_READ = 3'd0, M_ID = 3'd1, M_PROG = 3'd2, M_WINDOW = 3'd3,
    M_ERASE = 3'd4, M_SUSP = 3'd5, M_SPROG = 3'd6, M_FAULT = 3'd7
  } mode_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureOp;
    logic loadSector;
    logic fillMask;
    logic clearMask;
  } strobe_t;

  // Sector index of a 17-bit address (boot blocks at the top)
  function automatic logic [2:0] sectorOf(input logic [16:0] a);
    logic [2:0] idx;
    if (!a[16])      idx = 3'd0;
    else if (!a[15]) idx = 3'd1;
    else begin
      case (a[14:12])
        3'b000, 3'b001: idx = 3'd2;
        3'b010, 3'b011: idx = 3'd3;
        3'b100:         idx = 3'd4;
        3'b101:         idx = 3'd5;
        default:        idx = 3'd6;
      endcase
    end
    return idx;
  endfunction

endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int WIN_CYCLES = 1500,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'h19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              chipProtected,
  input  strobe_t           stb,
  input  logic              inWindow,
  input  logic              idMode,
  output logic              wrEvt,
  output logic [ADDR_W-1:0] addrLat,
  output logic [7:0]        dataLat,
  output logic              winExpired,
  output logic [NSECT-1:0]  sectorMask,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic [7:0]        idData
);

  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CYCLES - 1);

  // Two-stage synchronizer for {ce, we, oe}; idle value is all high
  logic [2:0] syncA, syncB;
  logic wrQ, wrQd, wrOpen, wrClose;
  logic [CNT_W-1:0] winCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 3'b111;
      syncB <= 3'b111;
      wrQd  <= 1'b0;
    end else begin
      syncA <= {ceN, weN, oeN};
      syncB <= syncA;
      wrQd  <= wrQ;
    end
  end

  assign wrQ     = ~syncB[2] & ~syncB[1] & syncB[0];
  assign wrOpen  = wrQ & ~wrQd;
  assign wrClose = ~wrQ & wrQd;

  // Address on the opening edge, data on the closing edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLat <= '0;
      dataLat <= '0;
      wrEvt   <= 1'b0;
    end else begin
      wrEvt <= wrClose;
      if (wrOpen)  addrLat <= addr;
      if (wrClose) dataLat <= dataIn;
    end
  end

  // Operation latch and sector mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr     <= '0;
      opData     <= '0;
      sectorMask <= '0;
    end else begin
      if (stb.captureOp) begin
        opAddr <= addrLat;
        opData <= dataLat;
      end
      if (stb.clearMask)       sectorMask <= '0;
      else if (stb.fillMask)   sectorMask <= '1;
      else if (stb.loadSector) sectorMask <= sectorMask | (NSECT'(1) << sectorOf(addrLat[16:0]));
    end
  end

  // Sector-load window, restarted by each load
  always_ff @(posedge clk) begin
    if (!rstN) winCnt <= '0;
    else if (!inWindow || stb.loadSector) winCnt <= '0;
    else if (winCnt != CNT_LAST) winCnt <= winCnt + 1'b1;
  end

  assign winExpired = inWindow && (winCnt == CNT_LAST) && !stb.loadSector;

  // Identifier read path
  always_comb begin
    if (!idMode)      idData = 8'h00;
    else if (addr[1]) idData = {7'b0, chipProtected};
    else if (addr[0]) idData = DEV_CODE;
    else              idData = MFR_CODE;
  end

  // R8: the window counter never passes its limit
  a_r8_win_bound: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= CNT_LAST);

  // R3: a write event needs a preceding qualified write phase
  a_r3_event_after_write: assert property (@(posedge clk) disable iff (!rstN)
    wrClose |=> wrEvt);

endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEvt,
  input  logic [ADDR_W-1:0] addrLat,
  input  logic [7:0]        dataLat,
  input  logic              winExpired,
  input  logic              engDone,
  input  logic              engFail,
  output strobe_t           stb,
  output mode_t             mode,
  output logic              inWindow,
  output logic              progStart,
  output logic              eraseStart,
  output logic              chipErase,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic              protUnlock
);

  typedef enum logic [4:0] {
    S_READ, S_U1, S_U2, S_ID, S_PWAIT, S_E0, S_E1, S_E2, S_PROG,
    S_WIN, S_ERASE, S_SUSP, S_SU1, S_SU2, S_SPWAIT, S_SPROG, S_FAULT
  } state_t;

  state_t st, nxt;
  logic nProg, nErase, nChip, nSusp, nResume, nProt;
  logic at555, at2AA, isAA, is55;

  assign at555 = addrLat[10:0] == 11'h555;
  assign at2AA = addrLat[10:0] == 11'h2AA;
  assign isAA  = at555 && dataLat == 8'hAA;
  assign is55  = at2AA && dataLat == 8'h55;

  always_comb begin
    nxt = st;
    stb = '0;
    {nProg, nErase, nChip, nSusp, nResume, nProt} = '0;
    case (st)
      S_READ, S_ID: if (wrEvt) nxt = isAA ? S_U1 : S_READ;
      S_U1:   if (wrEvt) nxt = is55 ? S_U2 : S_READ;
      S_U2:   if (wrEvt) begin
        nxt = S_READ;
        if (at555 && dataLat == 8'hA0) nxt = S_PWAIT;
        if (at555 && dataLat == 8'h90) nxt = S_ID;
        if (at555 && dataLat == 8'h80) begin
          nxt = S_E0;
          stb.clearMask = 1'b1;
        end
      end
      S_PWAIT: if (wrEvt) begin
        stb.captureOp = 1'b1;
        nProg = 1'b1;
        nxt = S_PROG;
      end
      S_E0:   if (wrEvt) nxt = isAA ? S_E1 : S_READ;
      S_E1:   if (wrEvt) nxt = is55 ? S_E2 : S_READ;
      S_E2:   if (wrEvt) begin
        nxt = S_READ;
        if (at555 && dataLat == 8'h10) begin
          stb.fillMask = 1'b1;
          nErase = 1'b1;
          nChip = 1'b1;
          nxt = S_ERASE;
        end else if (dataLat == 8'h30) begin
          stb.loadSector = 1'b1;
          nxt = S_WIN;
        end else if (at555 && dataLat == 8'h20) begin
          nProt = 1'b1;
        end
      end
      S_PROG: if (engFail) nxt = S_FAULT;
              else if (engDone) nxt = S_READ;
      S_WIN:  if (wrEvt) begin
        if (dataLat == 8'h30) stb.loadSector = 1'b1;
        else if (dataLat == 8'hB0) begin
          nErase = 1'b1;
          nSusp = 1'b1;
          nxt = S_SUSP;
        end else begin
          stb.clearMask = 1'b1;
          nxt = S_READ;
        end
      end else if (winExpired) begin
        nErase = 1'b1;
        nxt = S_ERASE;
      end
      S_ERASE: if (engFail) nxt = S_FAULT;
        else if (engDone) begin
          stb.clearMask = 1'b1;
          nxt = S_READ;
        end else if (wrEvt && dataLat == 8'hB0) begin
          nSusp = 1'b1;
          nxt = S_SUSP;
        end
      S_SUSP: if (wrEvt) begin
        if (dataLat == 8'h30) begin
          nResume = 1'b1;
          nxt = S_ERASE;
        end else if (isAA) nxt = S_SU1;
      end
      S_SU1:  if (wrEvt) nxt = is55 ? S_SU2 : S_SUSP;
      S_SU2:  if (wrEvt) nxt = (at555 && dataLat == 8'hA0) ? S_SPWAIT : S_SUSP;
      S_SPWAIT: if (wrEvt) begin
        stb.captureOp = 1'b1;
        nProg = 1'b1;
        nxt = S_SPROG;
      end
      S_SPROG: if (engFail) nxt = S_FAULT;
               else if (engDone) nxt = S_SUSP;
      S_FAULT: if (wrEvt && dataLat == 8'hF0) begin
        stb.clearMask = 1'b1;
        nxt = S_READ;
      end
      default: nxt = S_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= S_READ;
      {progStart, eraseStart, chipErase, suspendReq, resumeReq, protUnlock} <= '0;
    end else begin
      st <= nxt;
      progStart  <= nProg;
      eraseStart <= nErase;
      chipErase  <= nChip;
      suspendReq <= nSusp;
      resumeReq  <= nResume;
      protUnlock <= nProt;
    end
  end

  always_comb begin
    case (st)
      S_ID:                   mode = M_ID;
      S_PROG:                 mode = M_PROG;
      S_WIN:                  mode = M_WINDOW;
      S_ERASE:                mode = M_ERASE;
      S_SUSP, S_SU1, S_SU2, S_SPWAIT: mode = M_SUSP;
      S_SPROG:                mode = M_SPROG;
      S_FAULT:                mode = M_FAULT;
      default:                mode = M_READ;
    endcase
  end

  assign inWindow = st == S_WIN;

  // R5: programming holds until the engine answers
  a_r5_prog_holds: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_PROG && !engDone && !engFail) |=> st == S_PROG);

  // R10: a resume only leaves the suspended state
  a_r10_resume_from_susp: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> ($past(st) == S_SUSP && st == S_ERASE));

  // R2: never two engine starts at once
  a_r2_single_start: assert property (@(posedge clk) disable iff (!rstN)
    !(progStart && eraseStart));

  // R12: fault is left only by a reset write
  a_r12_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_FAULT && !wrEvt) |=> st == S_FAULT);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int WIN_CYCLES = 1500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              chipProtected,
  input  logic              engDone,
  input  logic              engFail,
  output logic              progStart,
  output logic              eraseStart,
  output logic              chipErase,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic              protUnlock,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic [NSECT-1:0]  sectorMask,
  output logic [2:0]        mode,
  output logic              idValid,
  output logic [7:0]        idData
);

  strobe_t stb;
  mode_t modeQ;
  logic wrEvt, winExpired, inWindow;
  logic [ADDR_W-1:0] addrLat;
  logic [7:0] dataLat;

  fcd_datapath #(.ADDR_W(ADDR_W), .WIN_CYCLES(WIN_CYCLES)) i_dp (
    .clk, .rstN, .ceN, .weN, .oeN, .addr, .dataIn, .chipProtected,
    .stb, .inWindow, .idMode(modeQ == M_ID),
    .wrEvt, .addrLat, .dataLat, .winExpired, .sectorMask, .opAddr, .opData, .idData
  );

  fcd_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk, .rstN, .wrEvt, .addrLat, .dataLat, .winExpired, .engDone, .engFail,
    .stb, .mode(modeQ), .inWindow,
    .progStart, .eraseStart, .chipErase, .suspendReq, .resumeReq, .protUnlock
  );

  assign mode    = modeQ;
  assign idValid = modeQ == M_ID;

  // R6: an erase is never launched with an empty sector set
  a_r6_mask_on_start: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> sectorMask != '0);

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WIN = 40;

  logic clk = 0, rstN = 0, ceN = 1, weN = 1, oeN = 1;
  logic [16:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic chipProtected = 0, engDone = 0, engFail = 0;
  logic progStart, eraseStart, chipErase, suspendReq, resumeReq, protUnlock, idValid;
  logic [16:0] opAddr;
  logic [7:0] opData, idData;
  logic [6:0] sectorMask;
  logic [2:0] mode;

  int checks = 0, errors = 0;
  int nProg = 0, nErase = 0, nChip = 0, nSusp = 0, nRes = 0, nProt = 0;
  logic [16:0] lastPA;
  logic [7:0] lastPD;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.WIN_CYCLES(WIN)) i_flash_cmd_decoder (
    .clk, .rstN, .ceN, .weN, .oeN, .addr, .dataIn, .chipProtected, .engDone, .engFail,
    .progStart, .eraseStart, .chipErase, .suspendReq, .resumeReq, .protUnlock,
    .opAddr, .opData, .sectorMask, .mode, .idValid, .idData
  );

  // Pulse monitor, away from the active edge
  always @(negedge clk) begin
    if (progStart) begin nProg++; lastPA = opAddr; lastPD = opData; end
    if (eraseStart) begin nErase++; if (chipErase) nChip++; end
    if (suspendReq) nSusp++;
    if (resumeReq) nRes++;
    if (protUnlock) nProt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrx(input logic [16:0] a, input logic [7:0] d, input logic oe);
    addr = a; dataIn = d; ceN = 0; oeN = oe;
    repeat (2) @(negedge clk);
    weN = 0;
    repeat (4) @(negedge clk);
    weN = 1;
    repeat (6) @(negedge clk);
    ceN = 1; oeN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    wrx(a, d, 1'b1);
  endtask

  task automatic unlock();
    wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h55);
  endtask

  task automatic erasePrefix();
    unlock(); wr(17'h00555, 8'h80); unlock();
  endtask

  task automatic pulseDone(input logic fail);
    @(negedge clk); if (fail) engFail = 1; else engDone = 1;
    @(negedge clk); engFail = 0; engDone = 0;
    repeat (2) @(negedge clk);
  endtask

  // Expected sector index computed from boundaries (R7)
  function automatic int expSector(input int a);
    if (a < 'h10000) return 0;
    if (a < 'h18000) return 1;
    if (a < 'h1A000) return 2;
    if (a < 'h1C000) return 3;
    if (a < 'h1D000) return 4;
    if (a < 'h1E000) return 5;
    return 6;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, e0;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 mask", sectorMask, 0);
    chk("R1 pulses", nProg + nErase + nSusp + nRes + nProt, 0);

    // R2 program, upper address bits set during unlock
    wr(17'h1D555, 8'hAA); wr(17'h0A2AA, 8'h55); wr(17'h18555, 8'hA0);
    wr(17'h12345, 8'h5A);
    chk("R2 prog count", nProg, 1);
    chk("R2 opAddr", lastPA, 'h12345);
    chk("R2 opData", lastPD, 'h5A);
    chk("R2 mode", mode, 2);

    // R5 writes ignored while programming
    wr(17'h00000, 8'hF0); wr(17'h00555, 8'hAA); wr(17'h00555, 8'hB0);
    chk("R5 mode holds", mode, 2);
    chk("R5 no extra start", nProg + nErase, 1);
    pulseDone(0);
    chk("R5 done to read", mode, 0);

    // R3 write with OE low is not seen
    p0 = nProg;
    wrx(17'h00555, 8'hAA, 1'b0);
    wr(17'h002AA, 8'h55); wr(17'h00555, 8'hA0); wr(17'h00100, 8'h11);
    chk("R3 no program", nProg, p0);
    chk("R3 mode", mode, 0);

    // R4 sweep: corrupt each prefix cycle in address then data
    for (int pos = 0; pos < 3; pos++) begin
      for (int kind = 0; kind < 2; kind++) begin
        logic [16:0] a[3];
        logic [7:0] d[3];
        a[0] = 17'h555; a[1] = 17'h2AA; a[2] = 17'h555;
        d[0] = 8'hAA; d[1] = 8'h55; d[2] = 8'hA0;
        if (kind == 0) a[pos] = a[pos] ^ 17'h004; else d[pos] = d[pos] ^ 8'h01;
        p0 = nProg;
        for (int c = 0; c < 3; c++) wr(a[c], d[c]);
        wr(17'h00200, 8'h22);
        chk("R4 no start", nProg, p0);
        chk("R4 mode read", mode, 0);
      end
    end

    // R13 reset mid-prefix
    unlock(); wr(17'h01234, 8'hF0);
    chk("R13 mode", mode, 0);
    p0 = nProg;
    wr(17'h00300, 8'hA0);
    chk("R13 no program after reset", nProg, p0);

    // R11 identifier read
    unlock(); wr(17'h00555, 8'h90);
    chk("R11 mode", mode, 1);
    chk("R11 idValid", idValid, 1);
    addr = 17'h00000; @(negedge clk); chk("R11 mfr", idData, 'hC2);
    addr = 17'h00001; @(negedge clk); chk("R11 dev", idData, 'h19);
    addr = 17'h00002; @(negedge clk); chk("R11 unprot", idData, 'h00);
    chipProtected = 1; @(negedge clk); chk("R11 prot", idData, 'h01);
    chipProtected = 0;
    wr(17'h00000, 8'hF0);
    chk("R11 exit", mode, 0);

    // R6 chip erase
    e0 = nErase;
    erasePrefix(); wr(17'h00555, 8'h10);
    chk("R6 start", nErase - e0, 1);
    chk("R6 chip flag", nChip, 1);
    chk("R6 mask", sectorMask, 'h7F);
    chk("R6 mode", mode, 4);
    pulseDone(0);
    chk("R6 done", mode, 0);

    // R7 sweep over sector boundaries
    for (int k = 0; k < 14; k++) begin
      int bases[8];
      int a;
      bases = '{'h00000, 'h10000, 'h18000, 'h1A000, 'h1C000, 'h1D000, 'h1E000, 'h20000};
      a = (k % 2 == 0) ? bases[k/2] : bases[k/2 + 1] - 1;
      erasePrefix(); wr(17'(a), 8'h30);
      repeat (WIN + 10) @(negedge clk);
      chk("R7 sector mask", sectorMask, 1 << expSector(a));
      chk("R8 expired to erase", mode, 4);
      pulseDone(0);
    end

    // R7/R8 multi-sector accumulation and window timing
    e0 = nErase;
    erasePrefix(); wr(17'h00100, 8'h30); wr(17'h1C010, 8'h30); wr(17'h1E000, 8'h30);
    chk("R7 window open", mode, 3);
    repeat (WIN - 10) @(negedge clk);
    chk("R8 still in window", mode, 3);
    chk("R8 no early start", nErase, e0);
    repeat (20) @(negedge clk);
    chk("R8 erase started", nErase - e0, 1);
    chk("R7 accumulated mask", sectorMask, 'h51);
    pulseDone(0);

    // R8 abort from window
    e0 = nErase;
    erasePrefix(); wr(17'h00000, 8'h30); wr(17'h00555, 8'h90);
    chk("R8 abort mode", mode, 0);
    repeat (WIN + 10) @(negedge clk);
    chk("R8 abort no erase", nErase, e0);

    // R9 suspend while erasing, R10 program while suspended and resume
    erasePrefix(); wr(17'h10000, 8'h30);
    repeat (WIN + 10) @(negedge clk);
    wr(17'h00000, 8'hB0);
    chk("R9 suspend pulse", nSusp, 1);
    chk("R9 suspended", mode, 5);
    p0 = nProg;
    unlock(); wr(17'h00555, 8'hA0); wr(17'h00040, 8'h3C);
    chk("R10 suspend program", nProg - p0, 1);
    chk("R10 mode 6", mode, 6);
    pulseDone(0);
    chk("R10 back to suspended", mode, 5);
    wr(17'h00000, 8'h30);
    chk("R10 resume pulse", nRes, 1);
    chk("R10 resumed", mode, 4);
    pulseDone(0);
    wr(17'h00000, 8'h30);
    chk("R10 resume without suspend", nRes, 1);
    chk("R10 mode read", mode, 0);

    // R9 B0 in window, then R12 fault
    e0 = nErase;
    erasePrefix(); wr(17'h1D000, 8'h30); wr(17'h00000, 8'hB0);
    chk("R9 window start", nErase - e0, 1);
    chk("R9 window suspend", nSusp, 2);
    chk("R9 window mode", mode, 5);
    wr(17'h00000, 8'h30);
    pulseDone(1);
    chk("R12 fault", mode, 7);
    wr(17'h00555, 8'hAA);
    chk("R12 fault holds", mode, 7);
    wr(17'h00000, 8'hF0);
    chk("R12 reset", mode, 0);

    // R14 protect unlock
    erasePrefix(); wr(17'h00555, 8'h20);
    chk("R14 pulse", nProt, 1);
    chk("R14 mode", mode, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule